// File: doc/BRIEF.md
# Phase-Frequency Detector With Steerable Polarity

This block compares two divided pulse trains, one from the RF (oscillator) divider and one from the reference divider, and turns the timing difference between their rising edges into two correction outputs for a charge pump. One output asks the pump to source current and the other asks it to sink current. Each input has its own edge-triggered flag. When both flags are set, they clear together on the next clock. Coincident edges therefore still give a one-cycle overlap on both outputs, so there is no dead band.

A single direction input selects the loop polarity. The same input also swaps which monitor output copies the RF pulse train and which copies the reference pulse train, so an external detector attached to the monitors sees the same reversal. A detector-enable input gates the pump outputs. A monitor-enable input gates the monitors. A two-bit gain code is decoded into a current multiplier for an external pump DAC, given in tenths.

Direction and gain changes are held back until neither flag is set, so that a correction pulse never changes meaning halfway through. All inputs are synchronous to `clk`.

Top module: `pfd_steer`

## Requirements
- R1: A rising edge on `div_rf_i` with no pending reference flag sets the RF flag. While the RF flag alone is set and the applied direction is 1, `pump_sink_o` is high and `pump_source_o` is low. Holding the input high does not set the flag again after it clears.
- R2: With applied direction 0 the polarity is reversed. A pending RF flag alone drives `pump_source_o`, and a pending reference flag alone drives `pump_sink_o`. With direction 1, a pending reference flag alone drives `pump_source_o`.
- R3: When both flags are set, both pump outputs are high for exactly one cycle, and then both flags clear. Edges on both inputs in the same cycle give that one-cycle overlap.
- R4: While `pd_en_i` is low, both pump outputs are low. The flags keep running, so the outputs reappear as soon as the enable returns.
- R5: The monitor outputs are registered copies of the inputs, one cycle late. With applied direction 1, `mon_a_o` follows `div_rf_i` and `mon_b_o` follows `div_ref_i`. With direction 0 the two are exchanged.
- R6: While `mon_en_i` is low, both monitor outputs are low on the next cycle.
- R7: `gain_mult_o` gives the multiplier in tenths for the applied gain code. Code 2'b00 gives 10, 2'b01 gives 15, 2'b10 gives 25 and 2'b11 gives 40.
- R8: A new direction or gain code is adopted only at a clock edge where both flags were clear before the edge. Otherwise the previous value is kept.
- R9: Reset clears both flags and both monitors. It sets the applied direction to 1 and the applied gain code to 2'b11 (multiplier 40), matching inputs that default high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_rf_i | input | 1 | Divided RF pulse train |
| div_ref_i | input | 1 | Divided reference pulse train |
| dir_i | input | 1 | Loop direction request |
| pd_en_i | input | 1 | Pump output enable |
| mon_en_i | input | 1 | Monitor output enable |
| gain_code_i | input | 2 | Pump gain code request |
| pump_source_o | output | 1 | Request to source current |
| pump_sink_o | output | 1 | Request to sink current |
| mon_a_o | output | 1 | Monitor A (RF when direction is 1) |
| mon_b_o | output | 1 | Monitor B (reference when direction is 1) |
| gain_mult_o | output | MULT_W | Current multiplier in tenths |

## Verification
On every cycle, the assertions check several rules. A lone RF flag must map to the correct pump output for each direction. A disabled detector or disabled monitors must keep their outputs low. A set pair of flags must clear unless a fresh edge arrives. The multiplier must always be one of the four legal values. The applied direction and multiplier must stay still while a flag is pending. Only the bench scenarios can show whole sequences. These are: which input led, the exact one-cycle overlap for coincident edges, the monitor swap following a deferred direction change, the exact decode of each gain code, and the values restored by a reset in the middle of a correction.

// File: rtl/pfd_steer_pkg.sv
package pfd_steer_pkg;

    localparam int CODE_W     = 2;
    localparam int MULT_W_DEF = 6;
    localparam int NUM_CH     = 2;
    localparam int CH_RF      = 0;
    localparam int CH_REF     = 1;

    localparam logic [CODE_W-1:0] GAIN_RESET = 2'b11;
    localparam logic              DIR_RESET  = 1'b1;

    // multiplier in tenths for each gain code
    function automatic logic [MULT_W_DEF-1:0] mult_tenths(input logic [CODE_W-1:0] code);
        logic [MULT_W_DEF-1:0] m;
        case (code)
            2'b00:   m = MULT_W_DEF'(10);
            2'b01:   m = MULT_W_DEF'(15);
            2'b10:   m = MULT_W_DEF'(25);
            default: m = MULT_W_DEF'(40);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pfd_steer_core.sv
module pfd_steer_core #(
    parameter int NCH = pfd_steer_pkg::NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pulse_i,
    output logic [NCH-1:0] hit_o
);

    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [NCH-1:0] hit;
    } core_t;

    localparam core_t CORE_RST = '{prev: '0, hit: '0};

    core_t          st_q, st_d;
    logic [NCH-1:0] rise;
    logic           all_set;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_edge
            assign rise[g] = pulse_i[g] & ~st_q.prev[g];
        end
    endgenerate

    assign all_set = &st_q.hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pulse_i;
        for (int i = 0; i < NCH; i++) begin
            // joint clear once every channel has fired; a fresh edge restarts
            if (all_set) begin
                st_d.hit[i] = rise[i];
            end else begin
                st_d.hit[i] = st_q.hit[i] | rise[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = st_q.hit;

endmodule

// File: rtl/pfd_steer_hold.sv
module pfd_steer_hold #(
    parameter int MULT_W = pfd_steer_pkg::MULT_W_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              idle_i,
    input  logic                              dir_i,
    input  logic [pfd_steer_pkg::CODE_W-1:0]  gain_code_i,
    output logic                              dir_o,
    output logic [MULT_W-1:0]                 mult_o
);

    import pfd_steer_pkg::*;

    typedef struct packed {
        logic              dir;
        logic [CODE_W-1:0] code;
        logic [MULT_W-1:0] mult;
    } hold_t;

    localparam hold_t HOLD_RST = '{
        dir:  DIR_RESET,
        code: GAIN_RESET,
        mult: MULT_W'(mult_tenths(GAIN_RESET))
    };

    hold_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (idle_i) begin
            st_d.dir  = dir_i;
            st_d.code = gain_code_i;
        end
        st_d.mult = MULT_W'(mult_tenths(st_d.code));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HOLD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o  = st_q.dir;
    assign mult_o = st_q.mult;

endmodule

// File: rtl/pfd_steer_route.sv
module pfd_steer_route (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [pfd_steer_pkg::NUM_CH-1:0]   hit_i,
    input  logic [pfd_steer_pkg::NUM_CH-1:0]   pulse_i,
    input  logic                               dir_i,
    input  logic                               pd_en_i,
    input  logic                               mon_en_i,
    output logic                               sink_o,
    output logic                               source_o,
    output logic                               mon_a_o,
    output logic                               mon_b_o
);

    import pfd_steer_pkg::*;

    typedef struct packed {
        logic mon_a;
        logic mon_b;
    } mon_t;

    localparam mon_t MON_RST = '{mon_a: 1'b0, mon_b: 1'b0};

    mon_t st_q, st_d;
    logic ch_sink, ch_source;

    // direction picks which flag asks for sink and which for source
    always_comb begin
        ch_sink   = dir_i ? hit_i[CH_RF]  : hit_i[CH_REF];
        ch_source = dir_i ? hit_i[CH_REF] : hit_i[CH_RF];
        sink_o    = pd_en_i & ch_sink;
        source_o  = pd_en_i & ch_source;
    end

    always_comb begin
        st_d       = st_q;
        st_d.mon_a = mon_en_i & (dir_i ? pulse_i[CH_RF]  : pulse_i[CH_REF]);
        st_d.mon_b = mon_en_i & (dir_i ? pulse_i[CH_REF] : pulse_i[CH_RF]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MON_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mon_a_o = st_q.mon_a;
    assign mon_b_o = st_q.mon_b;

endmodule

// File: rtl/pfd_steer.sv
module pfd_steer #(
    parameter int MULT_W = pfd_steer_pkg::MULT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_rf_i,
    input  logic              div_ref_i,
    input  logic              dir_i,
    input  logic              pd_en_i,
    input  logic              mon_en_i,
    input  logic [1:0]        gain_code_i,
    output logic              pump_source_o,
    output logic              pump_sink_o,
    output logic              mon_a_o,
    output logic              mon_b_o,
    output logic [MULT_W-1:0] gain_mult_o
);

    import pfd_steer_pkg::*;

    logic [NUM_CH-1:0] pulses;
    logic [NUM_CH-1:0] hit;
    logic              dir_now;
    logic              idle;

    assign pulses[CH_RF]  = div_rf_i;
    assign pulses[CH_REF] = div_ref_i;
    assign idle           = ~|hit;

    pfd_steer_core #(.NCH(NUM_CH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulses),
        .hit_o   (hit)
    );

    pfd_steer_hold #(.MULT_W(MULT_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_i      (idle),
        .dir_i       (dir_i),
        .gain_code_i (gain_code_i),
        .dir_o       (dir_now),
        .mult_o      (gain_mult_o)
    );

    pfd_steer_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .pulse_i  (pulses),
        .dir_i    (dir_now),
        .pd_en_i  (pd_en_i),
        .mon_en_i (mon_en_i),
        .sink_o   (pump_sink_o),
        .source_o (pump_source_o),
        .mon_a_o  (mon_a_o),
        .mon_b_o  (mon_b_o)
    );

endmodule

// File: rtl/pfd_steer_chk.sv
module pfd_steer_chk #(
    parameter int MULT_W = pfd_steer_pkg::MULT_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_rf_i,
    input logic              div_ref_i,
    input logic              pd_en_i,
    input logic              mon_en_i,
    input logic [1:0]        hit,
    input logic              dir_now,
    input logic              pump_source_o,
    input logic              pump_sink_o,
    input logic              mon_a_o,
    input logic              mon_b_o,
    input logic [MULT_W-1:0] gain_mult_o
);

    assert_rf_lead_sink_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en_i && dir_now && hit[0] && !hit[1]) |-> (pump_sink_o && !pump_source_o));

    assert_rf_lead_rev_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en_i && !dir_now && hit[0] && !hit[1]) |-> (pump_source_o && !pump_sink_o));

    assert_pair_clear_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && hit[1] && !div_rf_i) |=> !hit[0]);

    assert_pair_clear_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && hit[1] && !div_ref_i) |=> !hit[1]);

    assert_pd_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en_i |-> (!pump_sink_o && !pump_source_o));

    assert_mon_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en_i && dir_now) |=> (mon_a_o == $past(div_rf_i) && mon_b_o == $past(div_ref_i)));

    assert_mon_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> (!mon_a_o && !mon_b_o));

    assert_gain_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mult_o == MULT_W'(10) || gain_mult_o == MULT_W'(15) ||
         gain_mult_o == MULT_W'(25) || gain_mult_o == MULT_W'(40)));

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != 2'b00) |=> ($stable(dir_now) && $stable(gain_mult_o)));

endmodule

bind pfd_steer pfd_steer_chk #(.MULT_W(MULT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_rf_i      (div_rf_i),
    .div_ref_i     (div_ref_i),
    .pd_en_i       (pd_en_i),
    .mon_en_i      (mon_en_i),
    .hit           (hit),
    .dir_now       (dir_now),
    .pump_source_o (pump_source_o),
    .pump_sink_o   (pump_sink_o),
    .mon_a_o       (mon_a_o),
    .mon_b_o       (mon_b_o),
    .gain_mult_o   (gain_mult_o)
);

// File: tb/sim_pfd_steer.sv
`timescale 1ns/1ps
module sim_pfd_steer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rf = 1'b0, rf_ref = 1'b0, dir = 1'b1, pden = 1'b1, mon = 1'b1;
    logic [1:0] gain = 2'b11;
    logic       src, snk, ma, mb;
    logic [5:0] mult;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pfd_steer u0 (
        .clk(clk), .rst_n(rst_n), .div_rf_i(rf), .div_ref_i(rf_ref), .dir_i(dir),
        .pd_en_i(pden), .mon_en_i(mon), .gain_code_i(gain),
        .pump_source_o(src), .pump_sink_o(snk), .mon_a_o(ma), .mon_b_o(mb),
        .gain_mult_o(mult)
    );

    // {rf, ref, dir, pd_en, mon_en, gain[1:0], sink, source, mon_a, mon_b, mult[5:0]}
    localparam logic [16:0] VEC [26] = '{
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 0  idle, gain 00 adopted (R7 R8)
        17'b1_0_1_1_1_00_1_0_1_0_001010, // 1  RF edge -> sink (R1)
        17'b1_1_1_1_1_00_1_1_1_1_001010, // 2  ref edge -> overlap (R3)
        17'b1_1_1_1_1_00_0_0_1_1_001010, // 3  joint clear, held level no retrigger (R1 R3)
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 4
        17'b0_1_1_1_1_00_0_1_0_1_001010, // 5  ref leads -> source (R2)
        17'b0_0_1_1_1_00_0_1_0_0_001010, // 6  flag held
        17'b1_0_1_1_1_00_1_1_1_0_001010, // 7  overlap (R3)
        17'b1_0_1_1_1_00_0_0_1_0_001010, // 8  clear
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 9
        17'b1_1_1_1_1_00_1_1_1_1_001010, // 10 coincident edges (R3)
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 11
        17'b1_0_1_0_1_00_0_0_1_0_001010, // 12 pump disabled (R4)
        17'b1_0_1_1_1_00_1_0_1_0_001010, // 13 enable back, flag kept (R4)
        17'b0_1_1_1_1_00_1_1_0_1_001010, // 14
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 15
        17'b1_1_1_1_0_00_1_1_0_0_001010, // 16 monitors disabled (R6)
        17'b0_0_1_1_1_00_0_0_0_0_001010, // 17
        17'b0_0_1_1_1_01_0_0_0_0_001111, // 18 code 01 -> 15 (R7)
        17'b0_0_1_1_1_10_0_0_0_0_011001, // 19 code 10 -> 25 (R7)
        17'b0_0_1_1_1_11_0_0_0_0_101000, // 20 code 11 -> 40 (R7)
        17'b1_0_1_1_1_10_1_0_1_0_011001, // 21 idle before edge: adopted
        17'b1_0_1_1_1_00_1_0_1_0_011001, // 22 busy: gain held (R8)
        17'b1_1_1_1_1_00_1_1_1_1_011001, // 23 busy: held (R8)
        17'b1_1_1_1_1_00_0_0_1_1_011001, // 24 busy: held (R8)
        17'b0_0_1_1_1_00_0_0_0_0_001010  // 25 idle: adopted (R8)
    };

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_pump(input string what, input logic e_snk, input logic e_src);
        chk({what, " sink"}, int'(snk), int'(e_snk));
        chk({what, " source"}, int'(src), int'(e_src));
    endtask

    task automatic chk_mon(input string what, input logic e_a, input logic e_b);
        chk({what, " mon_a"}, int'(ma), int'(e_a));
        chk({what, " mon_b"}, int'(mb), int'(e_b));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // reset state (R9)
        #25;
        chk_pump("R9 reset", 1'b0, 1'b0);
        chk_mon("R9 reset", 1'b0, 1'b0);
        chk("R9 reset mult", int'(mult), 40);
        @(negedge clk);
        rst_n = 1'b1;
        #5;

        // table walk
        for (int i = 0; i < 26; i++) begin
            logic [16:0] v;
            string tag;
            v = VEC[i];
            rf = v[16]; rf_ref = v[15]; dir = v[14]; pden = v[13]; mon = v[12]; gain = v[11:10];
            tick();
            tag = $sformatf("vector %0d (R1 R3 R4 R5 R6 R7 R8)", i);
            chk_pump(tag, v[9], v[8]);
            chk_mon(tag, v[7], v[6]);
            chk({tag, " mult"}, int'(mult), int'(v[5:0]));
        end

        // R2: direction 0 while idle
        dir = 1'b0; tick();
        chk_pump("R2 dir0 idle", 1'b0, 1'b0);
        rf = 1'b1; tick();
        chk_pump("R2 rf lead dir0", 1'b0, 1'b1);
        chk_mon("R5 swapped", 1'b0, 1'b1);
        // R8: direction request while busy is deferred
        dir = 1'b1; tick();
        chk_pump("R8 dir held busy", 1'b0, 1'b1);
        rf_ref = 1'b1; tick();
        chk_pump("R3 overlap dir0", 1'b1, 1'b1);
        chk_mon("R5 swapped both", 1'b1, 1'b1);
        tick();
        chk_pump("R3 clear dir0", 1'b0, 1'b0);
        rf = 1'b0; rf_ref = 1'b0; tick();
        rf_ref = 1'b1; tick();
        chk_pump("R8 dir1 adopted ref lead", 1'b0, 1'b1);
        chk_mon("R5 dir1 routing", 1'b0, 1'b1);
        rf = 1'b1; tick();
        chk_pump("R3 overlap dir1", 1'b1, 1'b1);
        rf = 1'b0; rf_ref = 1'b0; tick();
        chk_pump("R3 cleared", 1'b0, 1'b0);

        // R2: reference leads with direction 0 -> sink
        dir = 1'b0; tick();
        rf_ref = 1'b1; tick();
        chk_pump("R2 ref lead dir0", 1'b1, 1'b0);
        rf_ref = 1'b0; tick();
        chk_pump("R2 ref flag held", 1'b1, 1'b0);
        rf = 1'b1; tick();
        chk_pump("R3 overlap ref lead", 1'b1, 1'b1);
        rf = 1'b0; tick();
        chk_pump("R3 clear ref lead", 1'b0, 1'b0);

        // R9: reset in the middle of a correction
        dir = 1'b0; gain = 2'b01; tick();
        chk("R7 code 01 mult", int'(mult), 15);
        rf = 1'b1; tick();
        chk_pump("R9 pre-reset pending", 1'b0, 1'b1);
        rst_n = 1'b0;
        #2;
        chk_pump("R9 mid reset pump", 1'b0, 1'b0);
        chk_mon("R9 mid reset mon", 1'b0, 1'b0);
        chk("R9 mid reset mult", int'(mult), 40);
        rf = 1'b0; dir = 1'b1; gain = 2'b11;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        rf_ref = 1'b1; tick();
        chk_pump("R9 direction 1 after reset", 1'b0, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule